// File: doc/BRIEF.md
# Shared Bus Arbiter with Grant Parking

This block decides which of several initiators on a shared synchronous bus may start the next transaction. Each initiator has its own active-low request line into the arbiter and its own active-low grant line out of it. Requests are sampled on every rising clock edge. The next owner is chosen while the current transaction is still on the bus, so the handover costs no separate arbitration cycles.

The choice is round-robin. The search for the next requester begins just after the last master that actually started a transaction. A master that was granted but never used the bus therefore does not lose its place. When nobody requests, the grant stays where it is (parking), so the holder can begin another transaction at once. When the grant has to move from one master to another, every grant line is held off for one cycle in between.

The arbiter watches the frame and initiator-ready lines of the bus. It learns which master became the bus owner by seeing a transaction begin: the bus was idle, a grant was present, and then frame was asserted. A parameter selects the reset state: either no grant at all, or a grant parked on master 0.

Top module: `shared_bus_arbiter`

## Requirements
- R1: There is one active-low request input and one active-low grant output per master, with bit i belonging to master i. After reset with PARK_ON_RESET=1, gnt_n is all ones except bit 0 (grant parked on master 0). With PARK_ON_RESET=0, gnt_n is all ones and stays so until the first request.
- R2: At most one bit of gnt_n is low in any cycle.
- R3: When the grant moves from one master to a different master, there is exactly one cycle between them in which every gnt_n bit is high.
- R4: When no grant is active and at least one request is sampled, the next cycle grants the first requesting master in the order last owner+1, last owner+2, and so on, wrapping at the master count, with the last owner itself tried last.
- R5: While a grant is active and no request is sampled, the grant stays on the same master.
- R6: An all-off handover cycle is always followed by a grant. If no request is sampled in that cycle, the grant parks on the last owner (master 0 if no transaction has started since reset).
- R7: A granted master that is itself the round-robin choice keeps its grant with no gap, whether or not the bus is busy.
- R8: While a grant is active and requests are sampled, the grant is withdrawn in the next cycle if the round-robin choice is a different master, even in the middle of a transaction.
- R9: A master becomes the last owner when it held the grant at an edge where frame_n and irdy_n were both high, and frame_n is low at the following edge. A grant that is never used leaves the last owner unchanged. The last owner resets to master 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | N_MASTERS | Per-master active-low bus request |
| frame_n | input | 1 | Active-low transaction frame of the shared bus |
| irdy_n | input | 1 | Active-low initiator-ready of the shared bus |
| gnt_n | output | N_MASTERS | Per-master active-low bus grant |

## Verification
The bound checker watches only the grant and request pins, on every cycle. It checks that there is never more than one grant, that any move between masters passes through one empty cycle, that a gap is always closed on the next cycle, that a grant given from the empty state goes to a requester, and that a parked or sole-requesting holder is left alone. Some behaviour can only be shown by the bench's scenarios, because it depends on history the pins do not reveal: the round-robin order, the last owner being set by an observed transaction start, the park target after a gap, and the two reset modes. The bench shows these by comparing two instances, one in each reset mode, against a behavioural model on every clock.

// File: rtl/sba_pkg.sv
package sba_pkg;
  // width of an index able to address n masters
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sba_reset_sync.sv
module sba_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int unsigned N_MASTERS = 4,
  localparam int unsigned IW = sba_pkg::idx_w(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IW-1:0]        last_idx,
  output logic                 any,
  output logic [IW-1:0]        pick_idx
);
  logic [IW:0] cand;

  // scan from the largest offset down so the nearest requester is written last
  always_comb begin
    any      = 1'b0;
    pick_idx = '0;
    cand     = '0;
    for (int off = N_MASTERS - 1; off >= 0; off--) begin
      cand = {1'b0, last_idx} + (IW+1)'(off) + (IW+1)'(1);
      if (cand >= (IW+1)'(N_MASTERS)) begin
        cand = cand - (IW+1)'(N_MASTERS);
      end
      if (req[cand[IW-1:0]]) begin
        any      = 1'b1;
        pick_idx = cand[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/sba_bus_watch.sv
module sba_bus_watch #(
  parameter int unsigned N_MASTERS = 4,
  localparam int unsigned IW = sba_pkg::idx_w(N_MASTERS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          gnt_vld,
  input  logic [IW-1:0] gnt_idx,
  output logic [IW-1:0] owner_idx
);
  logic          armed_q, armed_d;
  logic [IW-1:0] armed_idx_q, armed_idx_d;
  logic [IW-1:0] owner_q, owner_d;
  logic          bus_idle, start_seen, en;

  assign bus_idle   = frame_n & irdy_n;
  // granted on an idle bus at the last edge, frame asserted at this edge
  assign start_seen = armed_q & ~frame_n;

  always_comb begin
    armed_d     = bus_idle & gnt_vld;
    armed_idx_d = gnt_idx;
    owner_d     = start_seen ? armed_idx_q : owner_q;
    en          = (armed_d != armed_q) || (armed_idx_d != armed_idx_q) || (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      armed_idx_q <= '0;
      owner_q     <= '0;
    end else if (en) begin
      armed_q     <= armed_d;
      armed_idx_q <= armed_idx_d;
      owner_q     <= owner_d;
    end
  end

  assign owner_idx = owner_q;
endmodule

// File: rtl/sba_grant_ctl.sv
module sba_grant_ctl #(
  parameter int unsigned N_MASTERS     = 4,
  parameter bit          PARK_ON_RESET = 1'b1,
  localparam int unsigned IW = sba_pkg::idx_w(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pick_any,
  input  logic [IW-1:0]        pick_idx,
  input  logic [IW-1:0]        owner_idx,
  output logic                 gnt_vld,
  output logic [IW-1:0]        gnt_idx,
  output logic [N_MASTERS-1:0] gnt_hot
);
  localparam logic RST_VLD = PARK_ON_RESET;

  logic          vld_q, vld_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          park_ok_q, park_ok_d;
  logic          en;

  always_comb begin
    vld_d     = vld_q;
    idx_d     = idx_q;
    park_ok_d = park_ok_q;
    if (vld_q) begin
      // another master wins: open the one-cycle handover gap
      if (pick_any && (pick_idx != idx_q)) begin
        vld_d = 1'b0;
      end
    end else if (pick_any) begin
      vld_d     = 1'b1;
      idx_d     = pick_idx;
      park_ok_d = 1'b1;
    end else if (park_ok_q) begin
      vld_d = 1'b1;
      idx_d = owner_idx;
    end
    en = (vld_d != vld_q) || (idx_d != idx_q) || (park_ok_d != park_ok_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= RST_VLD;
      idx_q     <= '0;
      park_ok_q <= RST_VLD;
    end else if (en) begin
      vld_q     <= vld_d;
      idx_q     <= idx_d;
      park_ok_q <= park_ok_d;
    end
  end

  for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_dec
    assign gnt_hot[gi] = vld_q && (idx_q == IW'(gi));
  end

  assign gnt_vld = vld_q;
  assign gnt_idx = idx_q;
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int unsigned N_MASTERS     = 4,
  parameter bit          PARK_ON_RESET = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  output logic [N_MASTERS-1:0] gnt_n
);
  localparam int unsigned IW = sba_pkg::idx_w(N_MASTERS);

  logic                 rst_core_n;
  logic                 pick_any;
  logic [IW-1:0]        pick_idx;
  logic [IW-1:0]        owner_idx;
  logic                 gnt_vld;
  logic [IW-1:0]        gnt_idx;
  logic [N_MASTERS-1:0] gnt_hot;

  sba_reset_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  sba_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req      (~req_n),
    .last_idx (owner_idx),
    .any      (pick_any),
    .pick_idx (pick_idx)
  );

  sba_bus_watch #(.N_MASTERS(N_MASTERS)) u_watch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .gnt_vld   (gnt_vld),
    .gnt_idx   (gnt_idx),
    .owner_idx (owner_idx)
  );

  sba_grant_ctl #(.N_MASTERS(N_MASTERS), .PARK_ON_RESET(PARK_ON_RESET)) u_gnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx),
    .owner_idx (owner_idx),
    .gnt_vld   (gnt_vld),
    .gnt_idx   (gnt_idx),
    .gnt_hot   (gnt_hot)
  );

  assign gnt_n = ~gnt_hot;
endmodule

// File: rtl/shared_bus_arbiter_chk.sv
module shared_bus_arbiter_chk #(
  parameter int unsigned N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_n,
  input logic [N_MASTERS-1:0] gnt_n
);
  logic [N_MASTERS-1:0] g, r;
  assign g = ~gnt_n;
  assign r = ~req_n;

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g));

  a_r3_gap_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(g)) && (|g)) |-> (g == $past(g)));

  a_r4_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|g) && (|r)) |=> (|(g & $past(r))));

  a_r5_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|g) && !(|r)) |=> (g == $past(g)));

  a_r6_gap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|g) |=> (|g));

  a_r7_sole_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ((|g) && (r == g)) |=> (g == $past(g)));
endmodule

bind shared_bus_arbiter shared_bus_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .req_n (req_n),
  .gnt_n (gnt_n)
);

// File: tb/shared_bus_arbiter_tb_top.sv
module shared_bus_arbiter_tb_top;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NM-1:0] req_n = '1;
  logic          frame_n = 1'b1;
  logic          irdy_n = 1'b1;
  logic [NM-1:0] gnt_a_n, gnt_b_n;

  int  checks = 0;
  int  errors = 0;
  bit  started = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  shared_bus_arbiter #(.N_MASTERS(NM), .PARK_ON_RESET(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_a_n)
  );

  shared_bus_arbiter #(.N_MASTERS(NM), .PARK_ON_RESET(1'b0)) dut_nopark_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_b_n)
  );

  // behavioural model, one slot per instance: slot 0 parks at reset, slot 1 does not
  int m_gnt[2]   = '{0, -1};
  int m_owner[2] = '{0, 0};
  int m_cidx[2]  = '{0, 0};
  bit m_armed[2] = '{0, 0};
  bit m_park[2]  = '{1, 0};

  function automatic int rr_next(input logic [NM-1:0] r, input int last);
    for (int off = 0; off < NM; off++) begin
      if (r[(last + 1 + off) % NM]) return (last + 1 + off) % NM;
    end
    return -1;
  endfunction

  function automatic logic [NM-1:0] to_pins(input int idx);
    if (idx < 0) return '1;
    return ~(NM'(1) << idx);
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_gnt[k] = (k == 0) ? 0 : -1;
        m_owner[k] = 0; m_cidx[k] = 0; m_armed[k] = 0;
        m_park[k] = (k == 0);
      end else begin
        logic [NM-1:0] r;
        int  choice;
        bit  start, arm_nx;
        int  cidx_nx;
        r       = ~req_n;
        choice  = rr_next(r, m_owner[k]);
        start   = m_armed[k] && !frame_n;
        arm_nx  = frame_n && irdy_n && (m_gnt[k] >= 0);
        cidx_nx = m_gnt[k];
        if (m_gnt[k] >= 0) begin
          if (r != 0 && choice != m_gnt[k]) m_gnt[k] = -1;
        end else if (r != 0) begin
          m_gnt[k] = choice; m_park[k] = 1;
        end else if (m_park[k]) begin
          m_gnt[k] = m_owner[k];
        end
        if (start) m_owner[k] = m_cidx[k];
        m_armed[k] = arm_nx;
        m_cidx[k]  = cidx_nx;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R4 order, R6 park target, R9 owner tracking)
  always @(negedge clk) begin
    if (started && !done) begin
      check(gnt_a_n == to_pins(m_gnt[0]), "R4 model park-mode", gnt_a_n, to_pins(m_gnt[0]));
      check(gnt_b_n == to_pins(m_gnt[1]), "R9 model nogrant-mode", gnt_b_n, to_pins(m_gnt[1]));
    end
  end

  task automatic both(input logic [NM-1:0] ea, input logic [NM-1:0] eb, input string tag);
    check(gnt_a_n == ea, tag, gnt_a_n, ea);
    check(gnt_b_n == eb, tag, gnt_b_n, eb);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    started = 1'b1;
    both(4'b1110, 4'b1111, "R1 reset state");

    req_n = 4'b1011;                       // master 2 requests
    @(negedge clk);
    check(gnt_a_n == 4'b1111, "R3 gap leaving master 0", gnt_a_n, 4'b1111);
    check(gnt_b_n == 4'b1011, "R4 direct grant from empty", gnt_b_n, 4'b1011);
    @(negedge clk);
    both(4'b1011, 4'b1011, "R6 gap followed by grant");
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b0;         // master 2 starts
    @(negedge clk);
    both(4'b1011, 4'b1011, "R7 sole holder kept during transaction");
    repeat (2) @(negedge clk);
    frame_n = 1'b1;
    @(negedge clk);
    irdy_n = 1'b1;

    req_n = 4'b0101;                       // masters 1 and 3
    @(negedge clk);
    both(4'b1111, 4'b1111, "R8 withdrawn for other winner");
    @(negedge clk);
    both(4'b0111, 4'b0111, "R4 search starts after last owner");

    req_n = 4'b1111;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      both(4'b0111, 4'b0111, "R5 parked with no requests");
    end

    req_n = 4'b1101;                       // master 1, then withdraws in the gap
    @(negedge clk);
    both(4'b1111, 4'b1111, "R3 gap before move");
    req_n = 4'b1111;
    @(negedge clk);
    both(4'b1011, 4'b1011, "R9 park on last owner, unused grant ignored");

    req_n = 4'b0011;                       // masters 2 and 3, owner is 2
    @(negedge clk);
    both(4'b1111, 4'b1111, "R9 owner yields to next requester");
    @(negedge clk);
    both(4'b0111, 4'b0111, "R4 round-robin past owner");
    both(4'b0111, 4'b0111, "R2 single grant");

    for (int i = 0; i < 3000; i++) begin
      req_n   = NM'($urandom);
      frame_n = ($urandom % 4) != 0;
      irdy_n  = ($urandom % 3) != 0;
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule